// File: doc/BRIEF.md
# Successive-Approximation Converter Bus Read Interface

This block is the digital side of a 12-bit successive-approximation converter that sits on a processor bus. A read cycle is an active-low chip select and an active-low read both asserted. When the byte-select input is low, that read starts a conversion. The block signals the conversion with an active-low busy output. It steps a trial code out to an external DAC, one bit per clock and MSB first, and keeps or clears each trial bit from a one-bit comparator input. After 13 clocks it loads the result into an output latch.

The result is right justified and appears on a 12-bit data bus. The bus is modelled as an output-enable plus a data value. A wide host reads all 12 bits in one read with byte-select low. A byte-wide host reads the low byte with byte-select low, which also starts a conversion. It then reads the top four bits with byte-select high, which moves them onto the low lanes and starts nothing. A host can run in ROM style: it reads once to start a conversion and reads again later to collect the result. It can also run in wait-state style: it holds the read and waits on busy.

Top module: `adc_bus_read_if`

## Requirements
- R1: After reset, busy_n is 1, data_oe is 0, and the output latch holds 0, so the first full read returns 0.
- R2: data_oe is 1 exactly while cs_n and rd_n are both 0. A cycle with only one of them low neither enables the bus nor starts a conversion.
- R3: In a read with byte_hi = 0, data_out[11:0] equals the latched 12-bit result, with result bit 0 on data_out[0].
- R4: In a read with byte_hi = 1, data_out[3:0] carries result bits 11..8 and data_out[7:4] is 0.
- R5: Whenever data_out is enabled, data_out[11:8] carries result bits 11..8, whatever the level of byte_hi.
- R6: A conversion starts only on the clock where a read cycle is first seen and byte_hi is 0. A read with byte_hi = 1 leaves busy_n at 1.
- R7: busy_n goes low on the start edge and stays low for exactly 13 clock cycles. It returns to 1 on the edge that loads the new result into the latch.
- R8: While busy_n is 0, the bus shows the previous conversion's result.
- R9: The sequencer tests bits from MSB to LSB, one per clock. The comparator input is 1 when the analog input is at or above the trial code, and a 1 keeps the trial bit. The latched result is therefore the largest code not above the input.
- R10: A new start during a conversion restarts it from the MSB. busy_n then stays low for 13 cycles counted from the new start, and the latched result comes from the restarted conversion.
- R11: A read held low across many clocks starts only one conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| byte_hi | input | 1 | Byte select: 0 gives the full word or low byte and may start a conversion; 1 gives the high nibble on the low lanes |
| cmp_in | input | 1 | Comparator result for the current trial code |
| busy_n | output | 1 | Active-low conversion in progress |
| dac_code | output | 12 | Trial code for the external DAC |
| data_oe | output | 1 | Data bus drive enable (0 means high impedance) |
| data_out | output | 12 | Data bus value |

## Verification
The bench models an ideal analog input and answers each trial code arithmetically. It sweeps all 4096 input codes. Each code is read back three ways: as a full word on the next starting read, which also shows the previous result during busy, as the high nibble with byte select high, and on the upper lanes in both cases. The sweep alternates short ROM-style strobes with reads held for the whole conversion. This separates edge-triggered starts from level-triggered ones and confirms the 13-cycle busy window in both cases. Separate patterns assert only one of the two strobes, to show that no enable and no start follow. A mid-conversion restart with a changed input shows that the restart begins again from the MSB and that the result comes from the second input.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TEST = 2'd1,
        ST_LOAD = 2'd2
    } conv_state_e;
endpackage

// File: rtl/adc_strobe_edge.sv
module adc_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic byte_hi,
    output logic rd_active,
    output logic start
);
    typedef struct packed {
        logic seen;
    } strobe_t;

    strobe_t st_d, st_q;

    always_comb begin
        rd_active   = !cs_n && !rd_n;
        st_d        = st_q;
        st_d.seen   = rd_active;
        start       = rd_active && !st_q.seen && !byte_hi;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a start is only possible on the first cycle of a read
    p_single_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
    import adc_bus_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmp_in,
    output logic              busy_n,
    output logic [DATA_W-1:0] trial,
    output logic [DATA_W-1:0] result
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [DATA_W-1:0] MSB_MASK = DATA_W'(1) << (DATA_W - 1);
    localparam logic [DATA_W-1:0] LSB_MASK = DATA_W'(1);

    typedef struct packed {
        conv_state_e       state;
        logic [DATA_W-1:0] sar;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] latch;
        logic [CNT_W-1:0]  count;
    } seq_t;

    seq_t sq_d, sq_q;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.state)
            ST_TEST: begin
                if (cmp_in) sq_d.sar = sq_q.sar | sq_q.mask;
                sq_d.mask  = sq_q.mask >> 1;
                sq_d.count = sq_q.count + CNT_W'(1);
                if (sq_q.mask == LSB_MASK) sq_d.state = ST_LOAD;
            end
            ST_LOAD: begin
                sq_d.latch = sq_q.sar;
                sq_d.state = ST_IDLE;
            end
            default: ;
        endcase
        if (start) begin
            sq_d.state = ST_TEST;
            sq_d.sar   = '0;
            sq_d.mask  = MSB_MASK;
            sq_d.count = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q.state <= ST_IDLE;
            sq_q.sar   <= '0;
            sq_q.mask  <= '0;
            sq_q.latch <= '0;
            sq_q.count <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy_n = (sq_q.state == ST_IDLE);
    assign trial  = sq_q.sar | ((sq_q.state == ST_TEST) ? sq_q.mask : '0);
    assign result = sq_q.latch;

    // R7: every bit is tested once before the latch is loaded
    p_bit_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.state == ST_LOAD) |-> (sq_q.count == CNT_W'(DATA_W)));
    // R9: exactly one trial bit is under test at a time
    p_one_trial_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.state == ST_TEST) |-> ($countones(sq_q.mask) == 1));
    // R8: the latch only changes on the load step
    p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.state != ST_LOAD) |=> $stable(sq_q.latch));
endmodule

// File: rtl/adc_out_mux.sv
module adc_out_mux #(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              rd_active,
    input  logic              byte_hi,
    input  logic [DATA_W-1:0] result,
    output logic              oe,
    output logic [DATA_W-1:0] data
);
    localparam int HI_W = DATA_W - BYTE_W;

    always_comb begin
        oe   = rd_active;
        data = '0;
        if (rd_active) begin
            data = result;
            if (byte_hi) begin
                data[BYTE_W-1:0] = BYTE_W'(result[DATA_W-1 -: HI_W]);
            end
        end
    end
endmodule

// File: rtl/adc_bus_read_if.sv
module adc_bus_read_if #(
    parameter int DATA_W = 12,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              byte_hi,
    input  logic              cmp_in,
    output logic              busy_n,
    output logic [DATA_W-1:0] dac_code,
    output logic              data_oe,
    output logic [DATA_W-1:0] data_out
);
    localparam int HI_W = DATA_W - BYTE_W;

    logic              rd_active;
    logic              start;
    logic [DATA_W-1:0] result;

    adc_strobe_edge i_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .byte_hi   (byte_hi),
        .rd_active (rd_active),
        .start     (start)
    );

    adc_sar_seq #(.DATA_W(DATA_W)) i_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .cmp_in (cmp_in),
        .busy_n (busy_n),
        .trial  (dac_code),
        .result (result)
    );

    adc_out_mux #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_mux (
        .rd_active (rd_active),
        .byte_hi   (byte_hi),
        .result    (result),
        .oe        (data_oe),
        .data      (data_out)
    );

    // R5: upper lanes always carry the MSBs while driven
    p_msb_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (data_out[DATA_W-1 -: HI_W] == result[DATA_W-1 -: HI_W]));
    // R4: high-nibble read zeroes the gap lanes
    p_gap_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && byte_hi) |-> (data_out[BYTE_W-1:HI_W] == '0));
    // R6: byte-select high blocks a start
    p_no_start_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        byte_hi |-> !start);
    // R6: a start drops busy on the next cycle
    p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !busy_n);
    // R2: no drive outside a read cycle
    p_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> !data_oe);
endmodule

// File: tb/test_adc_bus_read_if.sv
module test_adc_bus_read_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        byte_hi = 1'b0;
    logic        cmp_in;
    logic        busy_n;
    logic [11:0] dac_code;
    logic        data_oe;
    logic [11:0] data_out;
    logic [11:0] vin = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    assign cmp_in = (vin >= dac_code);

    adc_bus_read_if i_adc_bus_read_if (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .byte_hi(byte_hi),
        .cmp_in(cmp_in), .busy_n(busy_n), .dac_code(dac_code),
        .data_oe(data_oe), .data_out(data_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Wait after a start edge; returns count of low-busy cycles
    task automatic count_busy(input bit hold, output int n);
        n = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (!hold && k == 0) begin cs_n = 1'b1; rd_n = 1'b1; end
            if (busy_n) break;
            n++;
        end
    endtask

    task automatic nibble_read(input int v, input string tag);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; byte_hi = 1'b0;
        @(negedge clk); byte_hi = 1'b1; cs_n = 1'b0; rd_n = 1'b0;
        #1;
        chk(data_out[3:0] == 4'(v >> 8), {tag, " R4 nibble"}, int'(data_out[3:0]), v >> 8);
        chk(data_out[7:4] == 4'd0, "R4 gap zero", int'(data_out[7:4]), 0);
        chk(data_out[11:8] == 4'(v >> 8), "R5 msb lanes", int'(data_out[11:8]), v >> 8);
        @(negedge clk);
        chk(busy_n == 1'b1, "R6 no start on byte_hi", int'(busy_n), 1);
        cs_n = 1'b1; rd_n = 1'b1; byte_hi = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int prev;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk(busy_n == 1'b1, "R1 busy after reset", int'(busy_n), 1);
        chk(data_oe == 1'b0, "R1 oe after reset", int'(data_oe), 0);

        // R2: one strobe only
        cs_n = 1'b0; rd_n = 1'b1; #1;
        chk(data_oe == 1'b0, "R2 cs only", int'(data_oe), 0);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0; #1;
        chk(data_oe == 1'b0, "R2 rd only", int'(data_oe), 0);
        @(negedge clk); rd_n = 1'b1;
        @(negedge clk);
        chk(busy_n == 1'b1, "R2 no start", int'(busy_n), 1);

        prev = 0;
        for (int v = 0; v < 4096; v++) begin
            bit hold;
            hold = v[0];
            @(negedge clk);
            vin = 12'(v); byte_hi = 1'b0; cs_n = 1'b0; rd_n = 1'b0;
            #1;
            chk(data_oe == 1'b1, "R2 oe in read", int'(data_oe), 1);
            chk(data_out == 12'(prev), (v == 0) ? "R1 first read" : "R3 full word", int'(data_out), prev);
            @(posedge clk);
            #1;
            chk(busy_n == 1'b0, "R7 busy on start", int'(busy_n), 0);
            if (hold) chk(data_out == 12'(prev), "R8 previous during busy", int'(data_out), prev);
            count_busy(hold, n);
            chk(n == 13, hold ? "R11 held read busy len" : "R7 busy len", n, 13);
            nibble_read(v, "R9");
            prev = v;
        end
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
        chk(data_out == 12'd4095, "R9 full scale", int'(data_out), 4095);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        count_busy(1'b0, n);
        prev = 4095;

        // R10: restart mid-conversion
        @(negedge clk); vin = 12'd100; cs_n = 1'b0; rd_n = 1'b0;
        @(posedge clk);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(busy_n == 1'b0, "R10 busy before restart", int'(busy_n), 0);
        vin = 12'd3000; cs_n = 1'b0; rd_n = 1'b0; #1;
        chk(data_out == 12'(prev), "R8 previous at restart", int'(data_out), prev);
        @(posedge clk);
        count_busy(1'b0, n);
        chk(n == 13, "R10 restart busy len", n, 13);
        nibble_read(3000, "R10");
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
        chk(data_out == 12'd3000, "R10 restart result", int'(data_out), 3000);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        repeat (16) @(negedge clk);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule